// File: doc/BRIEF.md
# Block-Write Configuration Serial Slave

This block is a two-wire serial slave that runs entirely on a system clock. It oversamples the SCL and SDA lines and pulls SDA low through an open-drain enable. It holds a bank of seven 8-bit configuration registers and exports them as one parallel bus, so neighbouring logic can use them directly, for example as per-output enable bits.

Writes follow a fixed block protocol. The host sends the write address, then two bytes that are acknowledged and thrown away, then data bytes. The data bytes always fill the registers from index 0 upward. Reads use the matching read address. The slave answers with a count byte followed by the registers in index order.

The behaviour is built around one state machine. Its states are:

- IDLE: waiting for a START.
- ADDR: receiving the address byte.
- ADDR_ACK: acknowledging a matched address.
- CMD and CMD_ACK: the discarded command byte and its acknowledge.
- CNT and CNT_ACK: the discarded count byte and its acknowledge.
- WDATA and WDATA_ACK: a data byte and its acknowledge.
- RDATA: shifting a byte out.
- RACK: sampling the host's acknowledge.
- WAIT_STOP: bus released, waiting for a condition.

The transitions are:

- IDLE→ADDR on START.
- ADDR→ADDR_ACK on a matching address. ADDR→WAIT_STOP on any other address.
- ADDR_ACK→CMD for a write. ADDR_ACK→RDATA for a read.
- CMD→CMD_ACK→CNT→CNT_ACK→WDATA.
- WDATA→WDATA_ACK→WDATA, repeating for each data byte.
- RDATA→RACK after eight bits.
- RACK→RDATA when the host acknowledges. RACK→WAIT_STOP when it does not.
- From any state: START goes to ADDR and STOP goes to IDLE.

Top module: `cfg_blkwr_slave`

## Requirements
- R1: While reset is asserted, and right after it, every register reads 0xFF on `cfg_regs` and `sda_oe` is 0.
- R2: The 8-bit address byte 0xD2 selects a write and 0xD3 selects a read, and both are acknowledged. Any other address is not acknowledged, and no later byte is acknowledged until the next START.
- R3: In a write, the first two bytes after the address are acknowledged, but their values change no register and do not limit how many data bytes are stored.
- R4: Write data bytes are received MSB first. The n-th data byte (n counted from 0) lands in register n, which appears on `cfg_regs[8n+7:8n]`, and every data byte is acknowledged.
- R5: A STOP after any complete data byte ends the write and leaves the registers that were not written unchanged.
- R6: Data bytes beyond register 6 are acknowledged and dropped.
- R7: A read returns the constant byte 7, then registers 0 to 6 in order, MSB first. Any byte requested after register 6 reads 0xFF.
- R8: If the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R9: A START or STOP in the middle of a byte abandons that byte without storing it, and a START restarts address reception.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs | output | 56 | Register n on bits [8n+7:8n] |

## Verification
The hardest situations to reach are the mid-byte aborts and the abandoned read. For the aborts, the bench clocks only part of a data byte and then issues a repeated START straight into a read-address transfer. This shows that the half byte never reached a register and that address reception restarted cleanly. For the abandoned read, the bench withholds the acknowledge after a read byte, then keeps toggling SCL with SDA released for a further byte, watching that the slave never pulls the line. Random-length block writes, including lengths of zero and lengths past the register bank, are each read back through the serial read path and on the parallel bus.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_CNT,
        ST_CNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } slv_state_e;

endpackage

// File: rtl/cfgslv_linesync.sv
module cfgslv_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // Synchroniser chains, idle level is high for both lines.
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // Data edges while the clock stays high mark bus conditions.
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank #(
    parameter int          NREG    = 7,
    parameter int          DW      = 8,
    parameter logic [DW-1:0] RST_VAL = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NREG+1)-1:0] wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic [$clog2(NREG+1)-1:0] rd_idx,
    output logic [DW-1:0]             rd_data,
    output logic [NREG*DW-1:0]        regs_flat
);
    localparam int IW = $clog2(NREG+1);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*DW +: DW] = regs[g];
    end

    // Past the last register the read path returns all ones.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/cfgslv_fsm.sv
module cfgslv_fsm
    import cfgslv_pkg::*;
#(
    parameter int          NREG    = 7,
    parameter logic [7:0]  WR_ADDR = 8'hD2,
    parameter logic [7:0]  RD_ADDR = 8'hD3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sda_s,
    input  logic                      scl_rise,
    input  logic                      scl_fall,
    input  logic                      start_det,
    input  logic                      stop_det,
    input  logic [7:0]                rd_data,
    output logic                      sda_oe,
    output logic                      wr_en,
    output logic [$clog2(NREG+1)-1:0] wr_idx,
    output logic [7:0]                wr_data,
    output logic [$clog2(NREG+1)-1:0] rd_idx,
    output slv_state_e                state
);
    localparam int          IW       = $clog2(NREG+1);
    localparam logic [IW-1:0] LAST_IX = IW'(NREG);
    localparam logic [7:0]  COUNT_B  = 8'(NREG);

    slv_state_e    state_q, state_d;
    logic [7:0]    shreg_q;
    logic [7:0]    txsh_q;
    logic [3:0]    bitcnt_q;
    logic          is_rd_q;
    logic          mack_q;
    logic [IW-1:0] wr_idx_q;
    logic [IW-1:0] rd_idx_q;
    logic          bit_full;

    assign bit_full = (bitcnt_q == 4'd8);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall && bit_full) begin
                        if (shreg_q == WR_ADDR || shreg_q == RD_ADDR) state_d = ST_ADDR_ACK;
                        else                                         state_d = ST_WAIT_STOP;
                    end
                end
                ST_ADDR_ACK:  if (scl_fall) state_d = is_rd_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (scl_fall && bit_full) state_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_d = ST_CNT;
                ST_CNT:       if (scl_fall && bit_full) state_d = ST_CNT_ACK;
                ST_CNT_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && bit_full) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mack_q ? ST_RDATA : ST_WAIT_STOP;
                ST_WAIT_STOP: state_d = ST_WAIT_STOP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            txsh_q   <= '0;
            bitcnt_q <= '0;
            is_rd_q  <= 1'b0;
            mack_q   <= 1'b0;
            wr_idx_q <= '0;
            rd_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_det || stop_det) begin
                bitcnt_q <= '0;
                wr_idx_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_CMD, ST_CNT, ST_WDATA: begin
                        if (scl_rise && !bit_full) begin
                            shreg_q  <= {shreg_q[6:0], sda_s};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end
                        if (scl_fall && bit_full) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_ADDR) is_rd_q <= (shreg_q == RD_ADDR);
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && is_rd_q) begin
                            txsh_q   <= COUNT_B;
                            rd_idx_q <= '0;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall && wr_idx_q != LAST_IX) wr_idx_q <= wr_idx_q + 1'b1;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                bitcnt_q <= '0;
                            end else begin
                                txsh_q   <= {txsh_q[6:0], 1'b1};
                                bitcnt_q <= bitcnt_q + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall && mack_q) begin
                            txsh_q <= rd_data;
                            if (rd_idx_q != LAST_IX) rd_idx_q <= rd_idx_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_CNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~txsh_q[7];
            ST_WDATA: wr_en  = scl_fall && bit_full && !start_det && !stop_det
                               && (wr_idx_q != LAST_IX);
            default: ;
        endcase
    end

    assign wr_idx  = wr_idx_q;
    assign wr_data = shreg_q;
    assign rd_idx  = rd_idx_q;
    assign state   = state_q;

endmodule

// File: rtl/cfg_blkwr_slave.sv
module cfg_blkwr_slave
    import cfgslv_pkg::*;
#(
    parameter int         NREG    = 7,
    parameter int         SYNC    = 2,
    parameter logic [7:0] WR_ADDR = 8'hD2,
    parameter logic [7:0] RD_ADDR = 8'hD3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs
);
    localparam int IW = $clog2(NREG+1);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;
    slv_state_e    fsm_state;

    cfgslv_linesync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfgslv_fsm #(.NREG(NREG), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .state(fsm_state)
    );

    cfgslv_regbank #(.NREG(NREG), .DW(8), .RST_VAL(8'hFF)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .regs_flat(cfg_regs)
    );

endmodule

// File: rtl/cfgslv_chk.sv
module cfgslv_chk
    import cfgslv_pkg::*;
#(
    parameter int NREG = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [NREG*8-1:0] cfg_regs,
    input slv_state_e        fsm_state
);
    // R1
    reset_vals_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_regs == '1) && !sda_oe);

    // R10
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_regs) |-> $past(wr_en));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> fsm_state == ST_IDLE);

    // R9
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> fsm_state == ST_ADDR);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RACK || fsm_state == ST_WAIT_STOP || fsm_state == ST_IDLE) |-> !sda_oe);

    // R6
    data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_WDATA_ACK |-> sda_oe);

    // R4
    store_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> fsm_state == ST_WDATA_ACK);

endmodule

bind cfg_blkwr_slave cfgslv_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en),
    .cfg_regs(cfg_regs), .fsm_state(fsm_state)
);

// File: tb/test_cfg_blkwr_slave.sv
`timescale 1ns/1ps
module test_cfg_blkwr_slave;
    localparam int NREG = 7;
    localparam int Q    = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NREG*8-1:0] cfg_regs;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] exp_r [NREG];
    logic [7:0] dbuf [16];

    always #4 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    cfg_blkwr_slave #(.NREG(NREG)) i_cfg_blkwr_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = !sda_bus; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl = 1'b0;
        end
        wq(1); sda_m = give_ack ? 1'b0 : 1'b1;
        wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(2); sda_m = 1'b1; wq(Q);
    endtask

    task automatic check_port(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, 32'(cfg_regs[i*8 +: 8]), 32'(exp_r[i]), $sformatf("cfg reg %0d", i));
    endtask

    // Block write of n data bytes with given command and count bytes
    task automatic wr_txn(input int n, input logic [7:0] cmd, input logic [7:0] cnt);
        bit ack;
        bus_start();
        send_byte(8'hD2, ack); chk("R2", 32'(ack), 1, "write address ack");
        send_byte(cmd, ack);   chk("R3", 32'(ack), 1, "command ack");
        send_byte(cnt, ack);   chk("R3", 32'(ack), 1, "count ack");
        check_port("R3");
        for (int i = 0; i < n; i++) begin
            send_byte(dbuf[i], ack);
            chk(i < NREG ? "R4" : "R6", 32'(ack), 1, $sformatf("data byte %0d ack", i));
            if (i < NREG) exp_r[i] = dbuf[i];
        end
        bus_stop();
        check_port("R5");
    endtask

    task automatic rd_txn();
        bit ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack); chk("R2", 32'(ack), 1, "read address ack");
        recv_byte(1'b1, b);    chk("R7", 32'(b), 7, "count byte");
        for (int i = 0; i < NREG; i++) begin
            recv_byte(1'b1, b); chk("R7", 32'(b), 32'(exp_r[i]), $sformatf("read reg %0d", i));
        end
        recv_byte(1'b0, b);    chk("R7", 32'(b), 32'hFF, "read past end");
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        int n;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'hFF;
        wq(5);
        // R1: reset state
        check_port("R1");
        chk("R1", 32'(sda_oe), 0, "sda_oe in reset");
        rst_n = 1'b1;
        wq(10);
        check_port("R1");
        chk("R1", 32'(sda_oe), 0, "sda_oe after reset");

        // R3/R4: count byte says 3 but all seven are stored
        for (int i = 0; i < NREG; i++) dbuf[i] = 8'(8'h10 * i + 8'h05 + i);
        wr_txn(NREG, 8'h00, 8'h03);
        rd_txn();

        // R5: stop after three bytes
        dbuf[0] = 8'hA5; dbuf[1] = 8'h3C; dbuf[2] = 8'h00;
        wr_txn(3, 8'h5A, 8'hFF);

        // R6: overflow bytes dropped
        for (int i = 0; i < 10; i++) dbuf[i] = 8'(8'hC1 + 8'(i * 3));
        wr_txn(10, 8'h01, 8'h0A);
        rd_txn();

        // R2: foreign address ignored, later bytes not acked
        bus_start();
        send_byte(8'hA4, ack); chk("R2", 32'(ack), 0, "foreign address nack");
        send_byte(8'h00, ack); chk("R2", 32'(ack), 0, "byte after foreign address");
        bus_stop();
        bus_start();
        send_byte(8'hD0, ack); chk("R2", 32'(ack), 0, "near-miss address nack");
        bus_stop();
        check_port("R2");

        // R9: partial byte then repeated start into a read
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_byte(8'h69, ack); exp_r[0] = 8'h69;
        send_bits(8'h00, 4);
        bus_start();
        check_port("R9");
        send_byte(8'hD3, ack); chk("R9", 32'(ack), 1, "address after repeated start");
        recv_byte(1'b1, b);    chk("R9", 32'(b), 7, "count after repeated start");
        recv_byte(1'b0, b);    chk("R9", 32'(b), 32'(exp_r[0]), "reg0 after abort");

        // R8: host withholds ack, slave stays off the bus
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl = 1'b1; wq(Q);
            chk("R8", 32'(sda_oe), 0, $sformatf("released after nack bit %0d", i));
            wq(Q); scl = 1'b0;
        end
        bus_stop();
        check_port("R8");

        // R4/R5/R6: random-length writes checked on the bus and the port
        for (int it = 0; it < 6; it++) begin
            n = (it == 0) ? 0 : int'($urandom_range(1, 9));
            for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom);
            wr_txn(n, 8'($urandom), 8'($urandom));
            rd_txn();
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule